// File: doc/BRIEF.md
# Two-Wire Configuration Register Target

This block is a target on a two-wire serial bus (I2C/SMBus style) that lets an external host inspect and change a small bank of configuration registers. The host names the register in a command byte that follows the address byte. Bit 7 of that command chooses between a single-register access and a sequential block access. Each accepted data byte lands in its register at once, and the rest of the chip reads the whole bank at all times through a flat parallel view.

Two register bytes have fixed meanings. Byte 1 holds the two lowest bits of the target's 7-bit bus address, a start bit for the nonvolatile-store copy engine, and a live busy flag. Byte 2 holds the number of bytes a block read returns. While the copy engine reports busy, the target refuses data bytes and still serves reads.

SDA and SCL are open-drain. The block sees each line as an input, and it pulls SDA low through a drive-enable output. Both inputs pass through two-flop synchronisers, and the block's system clock must run well above the bus bit rate.

Top module: `tw_cfg_target`

## Requirements
- R1: The target acknowledges only the 7-bit address formed by the fixed bits 11011 followed by register byte 1 bits [1:0]. After reset this address is 0x6C. For any other address the target does not acknowledge and leaves SDA released until the next START.
- R2: Bit 0 of the address byte sets the direction: 0 means the host writes, 1 means the host reads.
- R3: In the command byte, bit 7 set means byte mode and bit 7 clear means block mode. Bits [6:0] give the register offset. An offset of NUM_REGS or more is not acknowledged.
- R4: In byte mode the first data byte is written to the addressed register. Any further data byte in the same transaction is not acknowledged and changes nothing.
- R5: In block mode the data bytes go to ascending offsets, wrapping from NUM_REGS-1 to 0. If the host stops after any whole byte, every byte already acknowledged is kept.
- R6: Each accepted data byte appears on the parallel view by the end of its ACK clock pulse, without waiting for a STOP.
- R7: Read data is shifted out most significant bit first. A byte-mode read returns the addressed register and, if the host keeps acknowledging, returns that same register again.
- R8: A block read returns the registers from the command offset upward, wrapping at the top, for as many bytes as register byte 2 holds. Every byte after that reads 0xFF.
- R9: While ee_busy is 1, data bytes are not acknowledged and no register changes, but byte and block reads work normally. Busy is sampled when the eighth bit of a data byte ends.
- R10: Register byte 1 bit 6 reads ee_busy and bit 7 reads 0. Only bits [5:0] are stored. An accepted write to byte 1 with bit 7 set pulses ee_start high for exactly one clock.
- R11: A host NACK on a read byte returns the target to idle, so later clocks read 0xFF. A STOP also returns it to idle, and bytes clocked without a new START are not acknowledged.
- R12: After reset, every register is 0 except byte 2, which holds BCNT_RST (4 by default), ee_start is 0, and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | Pull SDA low when 1 |
| ee_busy | input | 1 | Copy engine reports a store cycle in progress |
| ee_start | output | 1 | One-clock request to start a store cycle |
| cfg_regs | output | NUM_REGS*8 | Parallel view of the bank, byte n at bits [8n+7:8n] |

## Verification
The case that needs care is a host data byte arriving while the busy interlock changes. The accept/reject decision and the register commit both happen on the same internal edge, at the falling SCL edge that ends the eighth bit. The bench raises ee_busy partway through a data byte and expects a NACK and an unchanged register. It then clears busy and repeats the write, expecting an ACK and the new value. It also checks that reads issued while busy still return the stored bank, with byte 1 bit 6 set.

// File: rtl/tw_cfg_pkg.sv
// Shared types and constants for the two-wire configuration target.
// Assumes the bank has at most 128 registers (the offset field is 7 bits).
package tw_cfg_pkg;

    // Protocol engine states
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK_ADDR,
        ST_CMD,
        ST_ACK_CMD,
        ST_WDATA,
        ST_ACK_W,
        ST_RDATA,
        ST_RACK
    } tw_state_t;

    // Fixed upper part of the 7-bit bus address
    localparam logic [4:0] TW_ADDR_HI = 5'b11011;
    // Register holding address low bits, busy flag and store trigger
    localparam int TW_CTRL_IDX = 1;
    // Register holding the block-read byte count
    localparam int TW_BCNT_IDX = 2;

endpackage

// File: rtl/tw_line_sync.sv
// Synchronises SCL/SDA into the system clock and flags bus events.
// Assumes clk runs several times faster than SCL; no further filtering.
module tw_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [2:0] scl_q;
    logic [2:0] sda_q;

    // Two synchroniser stages plus one history stage per line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 3'b111;
            sda_q <= 3'b111;
        end else begin
            scl_q <= {scl_q[1:0], scl_i};
            sda_q <= {sda_q[1:0], sda_i};
        end
    end

    assign scl_s     = scl_q[1];
    assign sda_s     = sda_q[1];
    assign scl_rise  = scl_q[1] & ~scl_q[2];
    assign scl_fall  = ~scl_q[1] & scl_q[2];
    assign start_det = scl_q[1] & scl_q[2] & sda_q[2] & ~sda_q[1];
    assign stop_det  = scl_q[1] & scl_q[2] & ~sda_q[2] & sda_q[1];

endmodule

// File: rtl/tw_cfg_bank.sv
// Configuration register bank with a flat parallel view.
// Byte CTRL stores only bits [5:0]; bit 6 shows ee_busy and bit 7 reads 0.
// Writing CTRL with bit 7 set raises ee_start for one clock.
module tw_cfg_bank #(
    parameter int NUM_REGS = 16,
    parameter int BCNT_RST = 4,
    localparam int AW = $clog2(NUM_REGS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [AW-1:0]         wr_addr,
    input  logic [7:0]            wr_data,
    input  logic [AW-1:0]         rd_addr,
    input  logic                  ee_busy,
    output logic [7:0]            rd_data,
    output logic [7:0]            byte_cnt,
    output logic [1:0]            addr_lo,
    output logic [NUM_REGS*8-1:0] cfg_flat,
    output logic                  ee_start
);
    import tw_cfg_pkg::*;

    localparam logic [AW-1:0] CTRL_A = AW'(TW_CTRL_IDX);

    logic [7:0] mem  [NUM_REGS];
    logic [7:0] view [NUM_REGS];

    // Register storage: reset values and host writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++)
                mem[i] <= (i == TW_BCNT_IDX) ? 8'(BCNT_RST) : 8'h00;
        end else if (wr_en) begin
            mem[wr_addr] <= (wr_addr == CTRL_A) ? {2'b00, wr_data[5:0]} : wr_data;
        end
    end

    // Store-cycle request pulse
    always_ff @(posedge clk) begin
        if (!rst_n) ee_start <= 1'b0;
        else        ee_start <= wr_en && (wr_addr == CTRL_A) && wr_data[7];
    end

    // Visible value of each register, with the status overlay on CTRL
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_view
        if (g == TW_CTRL_IDX) begin : g_ctrl
            assign view[g] = {1'b0, ee_busy, mem[g][5:0]};
        end else begin : g_plain
            assign view[g] = mem[g];
        end
        assign cfg_flat[g*8 +: 8] = view[g];
    end

    assign rd_data  = view[rd_addr];
    assign byte_cnt = mem[TW_BCNT_IDX];
    assign addr_lo  = mem[TW_CTRL_IDX][1:0];

endmodule

// File: rtl/tw_proto_fsm.sv
// Two-wire target protocol engine: address match, command decode,
// data receive with ACK, data transmit with host ACK sampling.
// Assumes synchronised line inputs and one-cycle edge/event strobes.
// SDA drive changes only on SCL falling edges.
module tw_proto_fsm #(
    parameter int NUM_REGS = 16,
    localparam int AW = $clog2(NUM_REGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          sda_s,
    input  logic          start_det,
    input  logic          stop_det,
    input  logic [1:0]    addr_lo,
    input  logic          ee_busy,
    input  logic [7:0]    rd_data,
    input  logic [7:0]    byte_cnt,
    output logic          sda_oe,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data,
    output logic [AW-1:0] ptr
);
    import tw_cfg_pkg::*;

    localparam logic [7:0]    NREG8 = 8'(NUM_REGS);
    localparam logic [AW-1:0] PTR_TOP = AW'(NUM_REGS - 1);

    tw_state_t   state;
    logic [7:0]  sh;
    logic [3:0]  bitcnt;
    logic        is_read;
    logic        byte_mode;
    logic        wrote_one;
    logic        host_ack;
    logic [7:0]  remain;
    logic [AW-1:0] ptr_nxt;
    logic [7:0]  tx_byte;
    logic        rx_done;

    // Next pointer with wrap at the top of the bank
    assign ptr_nxt = (ptr == PTR_TOP) ? '0 : ptr + 1'b1;
    // Byte to send next: register data, or 0xFF once the block count is used up
    assign tx_byte = (!byte_mode && remain == 8'd0) ? 8'hFF : rd_data;
    // A received byte is complete and its ACK slot begins
    assign rx_done = scl_fall && (bitcnt == 4'd8);

    // Bus protocol sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            sh        <= 8'h00;
            bitcnt    <= 4'd0;
            is_read   <= 1'b0;
            byte_mode <= 1'b0;
            wrote_one <= 1'b0;
            host_ack  <= 1'b0;
            remain    <= 8'd0;
            ptr       <= '0;
            sda_oe    <= 1'b0;
            wr_en     <= 1'b0;
            wr_addr   <= '0;
            wr_data   <= 8'h00;
        end else begin
            wr_en <= 1'b0;
            if (start_det) begin
                state  <= ST_ADDR;
                bitcnt <= 4'd0;
                sda_oe <= 1'b0;
            end else if (stop_det) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_CMD, ST_WDATA: begin
                        if (scl_rise && bitcnt != 4'd8) begin
                            sh     <= {sh[6:0], sda_s};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (rx_done) begin
                            bitcnt <= 4'd0;
                            if (state == ST_ADDR) begin
                                if (sh[7:1] == {TW_ADDR_HI, addr_lo}) begin
                                    is_read <= sh[0];
                                    remain  <= byte_cnt;
                                    sda_oe  <= 1'b1;
                                    state   <= ST_ACK_ADDR;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end else if (state == ST_CMD) begin
                                if ({1'b0, sh[6:0]} < NREG8) begin
                                    byte_mode <= sh[7];
                                    ptr       <= sh[AW-1:0];
                                    wrote_one <= 1'b0;
                                    sda_oe    <= 1'b1;
                                    state     <= ST_ACK_CMD;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end else begin
                                if (!ee_busy && !(byte_mode && wrote_one)) begin
                                    wr_en     <= 1'b1;
                                    wr_addr   <= ptr;
                                    wr_data   <= sh;
                                    wrote_one <= 1'b1;
                                    sda_oe    <= 1'b1;
                                    if (!byte_mode) ptr <= ptr_nxt;
                                end
                                state <= ST_ACK_W;
                            end
                        end
                    end
                    ST_ACK_ADDR, ST_ACK_CMD, ST_ACK_W: begin
                        if (scl_fall) begin
                            sda_oe <= 1'b0;
                            if (state == ST_ACK_ADDR && is_read) begin
                                sh     <= tx_byte;
                                sda_oe <= ~tx_byte[7];
                                bitcnt <= 4'd0;
                                state  <= ST_RDATA;
                                if (!byte_mode && remain != 8'd0) begin
                                    remain <= remain - 8'd1;
                                    ptr    <= ptr_nxt;
                                end
                            end else if (state == ST_ACK_ADDR) begin
                                state <= ST_CMD;
                            end else begin
                                state <= ST_WDATA;
                            end
                        end
                    end
                    ST_RDATA: begin
                        if (scl_fall) begin
                            if (bitcnt == 4'd7) begin
                                sda_oe <= 1'b0;
                                state  <= ST_RACK;
                            end else begin
                                sh     <= {sh[6:0], 1'b0};
                                sda_oe <= ~sh[6];
                                bitcnt <= bitcnt + 4'd1;
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) begin
                            host_ack <= ~sda_s;
                        end else if (scl_fall) begin
                            if (host_ack) begin
                                sh     <= tx_byte;
                                sda_oe <= ~tx_byte[7];
                                bitcnt <= 4'd0;
                                state  <= ST_RDATA;
                                if (!byte_mode && remain != 8'd0) begin
                                    remain <= remain - 8'd1;
                                    ptr    <= ptr_nxt;
                                end
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/tw_cfg_target.sv
// Top level: two-wire configuration register target.
// Connects line synchroniser, protocol engine and register bank.
// Assumes clk is at least about 8x the SCL rate.
module tw_cfg_target #(
    parameter int NUM_REGS = 16,
    parameter int BCNT_RST = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe,
    input  logic                  ee_busy,
    output logic                  ee_start,
    output logic [NUM_REGS*8-1:0] cfg_regs
);

    localparam int AW = $clog2(NUM_REGS);

    logic          sda_s;
    logic          scl_s;
    logic          scl_rise;
    logic          scl_fall;
    logic          start_det;
    logic          stop_det;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [7:0]    wr_data;
    logic [AW-1:0] ptr;
    logic [7:0]    rd_data;
    logic [7:0]    byte_cnt;
    logic [1:0]    addr_lo;

    tw_line_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_s     (scl_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    tw_proto_fsm #(.NUM_REGS(NUM_REGS)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .sda_s     (sda_s),
        .start_det (start_det),
        .stop_det  (stop_det),
        .addr_lo   (addr_lo),
        .ee_busy   (ee_busy),
        .rd_data   (rd_data),
        .byte_cnt  (byte_cnt),
        .sda_oe    (sda_oe),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .ptr       (ptr)
    );

    tw_cfg_bank #(.NUM_REGS(NUM_REGS), .BCNT_RST(BCNT_RST)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (ptr),
        .ee_busy  (ee_busy),
        .rd_data  (rd_data),
        .byte_cnt (byte_cnt),
        .addr_lo  (addr_lo),
        .cfg_flat (cfg_regs),
        .ee_start (ee_start)
    );

endmodule

// File: rtl/tw_cfg_target_chk.sv
// Property checker for tw_cfg_target, attached by bind below.
module tw_cfg_target_chk #(
    parameter int NUM_REGS = 16,
    localparam int AW = $clog2(NUM_REGS)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          scl_s,
    input logic          sda_oe,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr,
    input logic          ee_busy,
    input logic          ee_start
);

    AST_SDA_STABLE_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $past(scl_s) |-> $stable(sda_oe)); // R7

    AST_NO_COMMIT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !$past(ee_busy)); // R9

    AST_COMMIT_IN_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !scl_s); // R6

    AST_START_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ee_start |=> !ee_start); // R10

    AST_START_FROM_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ee_start |-> ($past(wr_en) && $past(wr_addr) == AW'(1))); // R10

endmodule

bind tw_cfg_target tw_cfg_target_chk #(.NUM_REGS(NUM_REGS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (scl_s),
    .sda_oe   (sda_oe),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .ee_busy  (ee_busy),
    .ee_start (ee_start)
);

// File: tb/tb_tw_cfg_target.sv
// Self-checking bench: a bus host model drives sweeps of addresses, offsets,
// counts and busy timing; expected values come from a bench-side model.
module tb_tw_cfg_target;

    localparam int NR = 16;
    localparam int Q  = 5;
    localparam int WD = 190000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_scl = 1'b1;
    logic host_sda = 1'b1;
    logic ee_busy = 1'b0;
    logic dut_oe;
    logic ee_start;
    logic [NR*8-1:0] cfg_regs;
    wire  sda_line = host_sda & ~dut_oe;

    int nvec = 0;
    int nfail = 0;
    int start_cnt = 0;
    bit done = 1'b0;
    logic [7:0] m [NR];
    logic [1:0] lo = 2'b00;

    always #2.5 clk = ~clk;

    tw_cfg_target #(.NUM_REGS(NR), .BCNT_RST(4)) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (host_scl),
        .sda_i    (sda_line),
        .sda_oe   (dut_oe),
        .ee_busy  (ee_busy),
        .ee_start (ee_start),
        .cfg_regs (cfg_regs)
    );

    always @(posedge clk) if (rst_n && ee_start) start_cnt++;

    task automatic chk(input string tag, input int act, input int exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] expv(input int r);
        return (r == 1) ? {1'b0, ee_busy, m[1][5:0]} : m[r];
    endfunction

    function automatic logic [6:0] dev();
        return {5'b11011, lo};
    endfunction

    task automatic hw(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        host_sda = 1'b1; hw(Q); host_scl = 1'b1; hw(2*Q);
        host_sda = 1'b0; hw(2*Q); host_scl = 1'b0; hw(Q);
    endtask

    task automatic bus_stop();
        host_sda = 1'b0; hw(Q); host_scl = 1'b1; hw(2*Q);
        host_sda = 1'b1; hw(2*Q);
    endtask

    task automatic put_bit(input bit b);
        host_sda = b; hw(Q); host_scl = 1'b1; hw(2*Q); host_scl = 1'b0; hw(Q);
    endtask

    task automatic get_bit(output bit b);
        host_sda = 1'b1; hw(Q); host_scl = 1'b1; hw(Q);
        b = sda_line; hw(Q); host_scl = 1'b0; hw(Q);
    endtask

    task automatic send_byte(input logic [7:0] v, input int busy_at, output bit acked);
        bit b;
        for (int i = 7; i >= 0; i--) begin
            if (i == busy_at) ee_busy = 1'b1;
            put_bit(v[i]);
        end
        get_bit(b);
        acked = !b;
    endtask

    task automatic recv_byte(input bit ack, output logic [7:0] v);
        bit b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(!ack);
    endtask

    // Byte-mode write of one register, checked against the model
    task automatic wr_one(input int r, input logic [7:0] v, input string tag);
        bit a;
        bus_start();
        send_byte({dev(), 1'b0}, -1, a); chk({tag, " addr ack"}, a, 1);
        send_byte(8'h80 | 8'(r), -1, a); chk({tag, " cmd ack"}, a, 1);
        send_byte(v, -1, a); chk({tag, " data ack"}, a, 1);
        m[r] = (r == 1) ? {2'b00, v[5:0]} : v;
        chk({tag, " view"}, int'(cfg_regs[r*8 +: 8]), int'(expv(r)));
        bus_stop();
        if (r == 1) lo = v[1:0];
    endtask

    // Byte-mode read of one register
    task automatic rd_one(input int r, output logic [7:0] v);
        bit a;
        bus_start();
        send_byte({dev(), 1'b0}, -1, a);
        send_byte(8'h80 | 8'(r), -1, a);
        bus_start();
        send_byte({dev(), 1'b1}, -1, a);
        recv_byte(1'b0, v);
        bus_stop();
    endtask

    initial begin
        repeat (WD) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL R11 watchdog act=running exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin
        bit a;
        logic [7:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        hw(2);

        // R12: reset state
        chk("R12 sda_oe", dut_oe, 0);
        chk("R12 ee_start", ee_start, 0);
        for (int r = 0; r < NR; r++) begin
            m[r] = (r == 2) ? 8'd4 : 8'd0;
            chk("R12 reset value", int'(cfg_regs[r*8 +: 8]), int'(m[r]));
        end

        // R1/R2: full address sweep, write direction
        for (int ad = 0; ad < 128; ad++) begin
            bus_start();
            send_byte({7'(ad), 1'b0}, -1, a);
            chk("R1 address match", a, (ad == 7'h6C) ? 1 : 0);
            bus_stop();
            chk("R11 released after stop", dut_oe, 0);
        end
        // R2: read direction also matched
        bus_start();
        send_byte({dev(), 1'b1}, -1, a);
        chk("R2 read direction ack", a, 1);
        recv_byte(1'b0, v);
        bus_stop();

        // R4/R6: byte writes to every register except the control byte
        for (int r = 0; r < NR; r++) begin
            if (r != 1) wr_one(r, 8'((r * 53 + 17) & 255), "R4 R6 byte write");
        end

        // R7: byte reads of every register
        for (int r = 0; r < NR; r++) begin
            rd_one(r, v);
            chk("R7 byte read", v, expv(r));
        end

        // R4: second data byte in byte mode is refused
        bus_start();
        send_byte({dev(), 1'b0}, -1, a);
        send_byte(8'h84, -1, a);
        send_byte(8'h3C, -1, a); chk("R4 first byte ack", a, 1);
        m[4] = 8'h3C;
        send_byte(8'hC3, -1, a); chk("R4 second byte nack", a, 0);
        bus_stop();
        chk("R4 register keeps first", int'(cfg_regs[4*8 +: 8]), 8'h3C);
        chk("R4 next register untouched", int'(cfg_regs[5*8 +: 8]), int'(m[5]));

        // R7: repeated ACK in byte mode returns the same register
        bus_start();
        send_byte({dev(), 1'b0}, -1, a);
        send_byte(8'h89, -1, a);
        bus_start();
        send_byte({dev(), 1'b1}, -1, a);
        recv_byte(1'b1, v); chk("R7 repeat first", v, m[9]);
        recv_byte(1'b0, v); chk("R7 repeat second", v, m[9]);
        // R11: after host NACK the target is idle
        recv_byte(1'b0, v); chk("R11 idle after nack", v, 8'hFF);
        bus_stop();

        // R3: out-of-range offsets are not acknowledged
        for (int c = NR; c < 128; c += 37) begin
            bus_start();
            send_byte({dev(), 1'b0}, -1, a);
            send_byte(8'h80 | 8'(c), -1, a);
            chk("R3 bad offset nack", a, 0);
            bus_stop();
        end

        // R5: block write wrapping from the top, then early stop
        bus_start();
        send_byte({dev(), 1'b0}, -1, a);
        send_byte(8'h0E, -1, a); chk("R3 block cmd ack", a, 1);
        for (int k = 0; k < 3; k++) begin
            send_byte(8'hA0 + 8'(k), -1, a);
            chk("R5 block data ack", a, 1);
            m[(14 + k) % NR] = 8'hA0 + 8'(k);
        end
        bus_stop();
        for (int r = 0; r < NR; r++)
            chk("R5 bank after block write", int'(cfg_regs[r*8 +: 8]), int'(expv(r)));
        bus_start();
        send_byte({dev(), 1'b0}, -1, a);
        send_byte(8'h03, -1, a);
        for (int k = 0; k < 5; k++) begin
            send_byte(8'h11 * 8'(k + 1), -1, a);
            m[3 + k] = 8'h11 * 8'(k + 1);
        end
        bus_stop();
        for (int r = 2; r < 10; r++)
            chk("R5 partial block kept", int'(cfg_regs[r*8 +: 8]), int'(expv(r)));

        // R8: block read over several starts and counts
        for (int si = 0; si < 2; si++) begin
            for (int c = 0; c < 6; c++) begin
                int s;
                s = (si == 0) ? 0 : 13;
                wr_one(2, 8'(c), "R8 set count");
                bus_start();
                send_byte({dev(), 1'b0}, -1, a);
                send_byte(8'(s), -1, a);
                bus_start();
                send_byte({dev(), 1'b1}, -1, a);
                for (int k = 0; k <= c; k++) begin
                    recv_byte(k != c, v);
                    chk("R8 block read", v, (k < c) ? expv((s + k) % NR) : 8'hFF);
                end
                bus_stop();
            end
        end

        // R1/R10: move the address; bit 6 written is not stored
        wr_one(1, 8'h7E, "R10 ctrl write");
        chk("R10 stored ctrl view", int'(cfg_regs[15:8]), 8'h3E);
        bus_start();
        send_byte({7'h6C, 1'b0}, -1, a); chk("R1 old address nack", a, 0);
        bus_stop();
        bus_start();
        send_byte({7'h6E, 1'b0}, -1, a); chk("R1 new address ack", a, 1);
        bus_stop();
        rd_one(1, v); chk("R10 ctrl readback", v, 8'h3E);

        // R10: store trigger pulse, then engine busy
        wr_one(1, 8'hBE, "R10 store trigger");
        hw(4);
        chk("R10 ee_start pulses", start_cnt, 1);
        ee_busy = 1'b1;
        hw(2);
        rd_one(1, v); chk("R10 busy bit reads 1", v, 8'h7E);

        // R9: writes refused while busy, reads still served
        bus_start();
        send_byte({dev(), 1'b0}, -1, a);
        send_byte(8'h85, -1, a); chk("R9 cmd ack while busy", a, 1);
        send_byte(8'hAA, -1, a); chk("R9 data nack while busy", a, 0);
        bus_stop();
        chk("R9 register unchanged", int'(cfg_regs[5*8 +: 8]), int'(m[5]));
        rd_one(5, v); chk("R9 read while busy", v, m[5]);
        ee_busy = 1'b0;
        hw(2);

        // R9: busy rises in the middle of a data byte
        bus_start();
        send_byte({dev(), 1'b0}, -1, a);
        send_byte(8'h86, -1, a);
        send_byte(8'h5A, 3, a); chk("R9 busy mid-byte nack", a, 0);
        bus_stop();
        chk("R9 mid-byte register unchanged", int'(cfg_regs[6*8 +: 8]), int'(m[6]));
        ee_busy = 1'b0;
        hw(2);
        wr_one(6, 8'h5A, "R9 write after busy clears");
        chk("R10 no extra ee_start", start_cnt, 1);

        // R11: after STOP, bytes without START are not acknowledged
        for (int i = 7; i >= 0; i--) begin
            host_scl = 1'b0; hw(Q);
            put_bit(dev()[0] ^ 1'b0);
        end
        get_bit(a);
        chk("R11 no ack without start", a, 1);
        host_scl = 1'b1; hw(Q);
        bus_stop();

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule